// File: doc/BRIEF.md
# Inter-core mailbox register bank

This block holds a set of 32-bit mailbox words that processor cores use to signal one another. Four cores each own four mailboxes, giving sixteen words in all. Any core can post bits into a mailbox by writing to its set address. The written value is OR-ed in, so two senders never need a read-modify-write to post bits without losing each other's.

The receiving core reads the mailbox at its clear address. It then writes back the bits it has handled, and those bits are removed. Every mailbox drives one pending flag, which is high while the word holds any 1 bit. The sixteen flags go to a separate interrupt router, which owns enable and routing policy.

Access uses a simple 32-bit register bus with a byte offset. Only word-aligned offsets inside the mailbox windows do anything.

Top module: `mbox_bank`

## Requirements
- R1: Reset (rst_n low) clears every mailbox word to zero and drives all pending flags low.
- R2: A write to offset 0x80 + 4×i (i = core×4 + slot, 0..15) ORs bus_wdata into mailbox i. The new value is visible on the clock edge that accepts the write.
- R3: A write to offset 0xC0 + 4×i clears each bit of mailbox i whose position is 1 in bus_wdata and leaves the other bits unchanged.
- R4: While bus_sel is high and bus_we is low at offset 0xC0 + 4×i, bus_rdata shows the current value of mailbox i in the same cycle. Reading has no side effect.
- R5: A read of the set window (0x80 to 0xBC) returns zero and changes no mailbox.
- R6: pending[i] is registered and is high exactly when mailbox i is nonzero. It changes on the same clock edge as the mailbox, so it is visible in the cycle after the write.
- R7: An access whose offset bits [1:0] are not 00 is ignored: a write changes no mailbox, and a read returns zero.
- R8: An access to an offset below 0x80 is ignored: a write changes no mailbox, and a read returns zero.
- R9: A write only touches the mailbox it addresses. Writing zero to a set or clear address leaves that mailbox unchanged.
- R10: When bus_sel is low, or during a write, bus_rdata is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset into the register window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle as the access |
| pending | output | 16 | Per-mailbox nonzero flag, bit i for mailbox i |

## Verification
The bench goes after the edges of the address decode.

- **Highest index.** It targets the last mailbox of the last core. A decode off by one word would leave pending bit 15 low or would set the wrong bit.
- **Misaligned and out-of-window offsets.** Writes of all ones to these offsets would corrupt some mailbox if the decode ignored the low address bits or the window base.
- **Set window reads.** A read of the set window must return zero, not mirror the mailbox.
- **Zero writes.** Zero-valued set and clear writes must leave the word unchanged. A decode that replaced the word instead of OR-ing or masking it would wipe the word.
- **Full clear.** Clearing the last bit must drop pending in the following cycle.
- **Reset in mid-run.** A reset with live mailboxes must clear both the contents and the flags.

// File: rtl/mbox_bank.sv
module mbox_bank #(
  parameter int CORES    = 4,
  parameter int SLOTS    = 4,
  parameter int DW       = 32,
  parameter int AW       = 8,
  parameter int SET_BASE = 'h80,
  parameter int CLR_BASE = 'hC0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_sel,
  input  logic                   bus_we,
  input  logic [AW-1:0]          bus_addr,
  input  logic [DW-1:0]          bus_wdata,
  output logic [DW-1:0]          bus_rdata,
  output logic [CORES*SLOTS-1:0] pending
);
  localparam int N    = CORES * SLOTS;
  localparam int IW   = $clog2(N);
  localparam int SPAN = N * 4;
  localparam logic [AW:0] SET_LO = (AW+1)'(SET_BASE);
  localparam logic [AW:0] SET_HI = (AW+1)'(SET_BASE + SPAN);
  localparam logic [AW:0] CLR_LO = (AW+1)'(CLR_BASE);
  localparam logic [AW:0] CLR_HI = (AW+1)'(CLR_BASE + SPAN);

  logic [DW-1:0]   mbox_q [N];
  logic [DW-1:0]   mbox_d [N];
  logic [N*DW-1:0] mbox_flat;

  wire [AW:0] ext     = {1'b0, bus_addr};
  wire        aligned = (bus_addr[1:0] == 2'b00);
  wire        hit_set = aligned && ext >= SET_LO && ext < SET_HI;
  wire        hit_clr = aligned && ext >= CLR_LO && ext < CLR_HI;
  wire [AW:0] set_off = ext - SET_LO;
  wire [AW:0] clr_off = ext - CLR_LO;
  wire [IW-1:0] set_idx = set_off[IW+1:2];
  wire [IW-1:0] clr_idx = clr_off[IW+1:2];

  wire wr_set = bus_sel && bus_we && hit_set;
  wire wr_clr = bus_sel && bus_we && hit_clr;
  wire rd_clr = bus_sel && !bus_we && hit_clr;

  assign bus_rdata = rd_clr ? mbox_q[clr_idx] : '0;

  for (genvar i = 0; i < N; i++) begin : g_mbox
    always_comb begin
      mbox_d[i] = mbox_q[i];
      if (wr_set && set_idx == IW'(i)) mbox_d[i] = mbox_q[i] | bus_wdata;
      if (wr_clr && clr_idx == IW'(i)) mbox_d[i] = mbox_q[i] & ~bus_wdata;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        mbox_q[i]  <= '0;
        pending[i] <= 1'b0;
      end else begin
        mbox_q[i]  <= mbox_d[i];
        pending[i] <= |mbox_d[i];
      end
    end

    assign mbox_flat[i*DW +: DW] = mbox_q[i];
  end
endmodule

// File: rtl/mbox_bank_chk.sv
module mbox_bank_chk #(
  parameter int N  = 16,
  parameter int DW = 32,
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_sel,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic [N-1:0]  pending,
  input logic [N*DW-1:0] mbox_flat
);
  localparam int IW = $clog2(N);

  logic          lw_set, lw_clr, rst_seen;
  logic [IW-1:0] lw_idx;
  logic [DW-1:0] lw_data;
  logic [N-1:0]  nz;

  always_comb
    for (int i = 0; i < N; i++) nz[i] = |mbox_flat[i*DW +: DW];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lw_set   <= 1'b0;
      lw_clr   <= 1'b0;
      lw_idx   <= '0;
      lw_data  <= '0;
      rst_seen <= 1'b1;
    end else begin
      lw_set  <= bus_sel && bus_we && bus_addr[1:0] == 2'b00 &&
                 bus_addr >= AW'('h80) && bus_addr < AW'('hC0);
      lw_clr  <= bus_sel && bus_we && bus_addr[1:0] == 2'b00 &&
                 bus_addr >= AW'('hC0);
      lw_idx  <= bus_addr[IW+1:2];
      lw_data <= bus_wdata;
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    (rst_seen === 1'b1 && !rst_n) |=> (pending == '0 && mbox_flat == '0));

  // R2
  set_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lw_set |-> ((mbox_flat[lw_idx*DW +: DW] & lw_data) == lw_data));

  // R3
  clr_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lw_clr |-> ((mbox_flat[lw_idx*DW +: DW] & lw_data) == '0));

  // R6
  pending_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pending == nz);

  // R5
  read_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_we) |=> $stable(mbox_flat));

  // R7
  misalign_ign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && bus_addr[1:0] != 2'b00) |=> $stable(mbox_flat));

  // R8
  low_ign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && bus_addr < AW'('h80)) |=> $stable(mbox_flat));
endmodule

bind mbox_bank mbox_bank_chk #(.N(CORES*SLOTS), .DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .pending(pending),
  .mbox_flat(mbox_flat)
);

// File: tb/mbox_bank_tb.sv
module mbox_bank_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] pending;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  mbox_bank u_dut (.clk, .rst_n, .bus_sel, .bus_we, .bus_addr, .bus_wdata,
                   .bus_rdata, .pending);

  // {req[3:0], we, addr[7:0], wdata[31:0], exp_rdata[31:0], exp_pending[15:0]}
  localparam int NV = 21;
  localparam logic [92:0] VEC [NV] = '{
    {4'd2,  1'b1, 8'h80, 32'h0000_00FF, 32'h0, 16'h0001}, // R2 R6 set slot 0
    {4'd4,  1'b0, 8'hC0, 32'h0,  32'h0000_00FF, 16'h0001}, // R4
    {4'd2,  1'b1, 8'h80, 32'h0000_FF00, 32'h0, 16'h0001}, // R2 OR-in
    {4'd4,  1'b0, 8'hC0, 32'h0,  32'h0000_FFFF, 16'h0001}, // R4
    {4'd3,  1'b1, 8'hC0, 32'h0000_00F0, 32'h0, 16'h0001}, // R3 partial clear
    {4'd3,  1'b0, 8'hC0, 32'h0,  32'h0000_FF0F, 16'h0001}, // R3
    {4'd2,  1'b1, 8'hBC, 32'h8000_0000, 32'h0, 16'h8001}, // R2 last index
    {4'd4,  1'b0, 8'hFC, 32'h0,  32'h8000_0000, 16'h8001}, // R4 last index
    {4'd5,  1'b0, 8'hBC, 32'h0,  32'h0,          16'h8001}, // R5 set-window read
    {4'd2,  1'b1, 8'h94, 32'h1234_5678, 32'h0, 16'h8021}, // R2 core1 slot1
    {4'd7,  1'b1, 8'hC2, 32'hFFFF_FFFF, 32'h0, 16'h8021}, // R7 misaligned write
    {4'd7,  1'b0, 8'hD6, 32'h0,  32'h0,          16'h8021}, // R7 misaligned read
    {4'd8,  1'b1, 8'h40, 32'hFFFF_FFFF, 32'h0, 16'h8021}, // R8 low write
    {4'd8,  1'b0, 8'h40, 32'h0,  32'h0,          16'h8021}, // R8 low read
    {4'd9,  1'b1, 8'h80, 32'h0,  32'h0,          16'h8021}, // R9 zero set
    {4'd9,  1'b1, 8'hC0, 32'h0,  32'h0,          16'h8021}, // R9 zero clear
    {4'd9,  1'b0, 8'hD4, 32'h0,  32'h1234_5678, 16'h8021}, // R9 isolation
    {4'd9,  1'b0, 8'hC0, 32'h0,  32'h0000_FF0F, 16'h8021}, // R9 zero writes kept
    {4'd6,  1'b1, 8'hC0, 32'h0000_FF0F, 32'h0, 16'h8020}, // R6 drop on full clear
    {4'd3,  1'b1, 8'hFC, 32'hFFFF_FFFF, 32'h0, 16'h0020}, // R3 clear all
    {4'd4,  1'b0, 8'hFC, 32'h0,  32'h0,          16'h0020}  // R4
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 pending after reset", 32'(pending), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    bus_sel = 1; bus_we = 0; bus_addr = 8'hC0;
    #1 check("R1 mailbox 0 after reset", bus_rdata, 32'h0);
    bus_sel = 0;
    #1 check("R10 idle rdata", bus_rdata, 32'h0);
    @(negedge clk);

    for (int k = 0; k < NV; k++) begin
      logic [92:0] v;
      string tag;
      v = VEC[k];
      tag = $sformatf("R%0d vector %0d", v[92:89], k);
      bus_sel = 1; bus_we = v[88]; bus_addr = v[87:80]; bus_wdata = v[79:48];
      #1 check({tag, " rdata"}, bus_rdata, v[47:16]);
      @(negedge clk);
      check({tag, " pending"}, 32'(pending), 32'(v[15:0]));
    end
    bus_sel = 0;

    // R6: a write's effect appears only after the edge
    bus_sel = 1; bus_we = 1; bus_addr = 8'h88; bus_wdata = 32'h1;
    #1 check("R6 pending before edge", 32'(pending), 32'h0020);
    @(negedge clk);
    check("R6 pending after edge", 32'(pending), 32'h0024);
    bus_sel = 0;

    // R1: reset in mid-run
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    check("R1 pending mid-run reset", 32'(pending), 32'h0);
    bus_sel = 1; bus_we = 0; bus_addr = 8'hD4;
    #1 check("R1 mailbox 5 mid-run reset", bus_rdata, 32'h0);
    bus_sel = 0;
    @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule